// File: doc/BRIEF.md
# Serial Input Port with Pattern-Match Event

This block turns a one-wire serial bit stream, sent by a remote serializer and sampled on the fabric clock, into a parallel word. The word width is fixed when the block is built. A frame strobe marks the first bit of every word. Each finished word goes into a received-value register that a host reads through a small register port.

The host can also load a pattern and a per-bit mask. Each finished word is compared with the pattern under the mask. On a hit the block pulses an event output for one cycle and sets a sticky flag, so a processor can wait for a given bit pattern instead of polling every word. Status bits report a word that has not been read yet and an overwritten word. The whole compare path can be removed by a build parameter; reception does not change when it is.

Top module: `serin_match`

## Requirements
- R1: `WIDTH` (2 to 32) sets the word size. Bits are sampled on rising clock edges, most significant first. The bit sampled with `ser_frame` high is the first bit of a word, and the word is complete when its `WIDTH`-th bit is sampled. From the next cycle the finished word reads at register index 0 (offset 0x0), zero-extended to 32 bits, and that value holds until the next word completes.
- R2: A bit sampled with `ser_frame` low while no word is in progress is ignored. A frame strobe during a partly received word drops the partial word and starts a new one.
- R3: Index 1 (offset 0x4) is the pattern and index 2 (offset 0x8) is the mask. Both are 32-bit read/write registers, and only their low `WIDTH` bits take part in the compare. Index 0 is read-only, and writes to it change nothing.
- R4: When a word completes and `((word ^ pattern) & mask)` is zero over the low `WIDTH` bits, `match_evt` is high for exactly one cycle: the first cycle in which the new word is readable. Mask bits set to 0 are don't-care.
- R5: Status bit 0 at index 3 (offset 0xC) is a sticky match flag. It is set with every event and cleared only by writing 1 to bit 0. Writing 0 leaves it unchanged, and a new event in the same cycle as a clear leaves it set.
- R6: Status bit 2 (word ready) is set when a word completes and cleared by a host read of index 0 (`host_rd` high with `host_addr` = 0).
- R7: Status bit 1 (overrun) is set when a word completes while word ready is still set. The new word replaces the old one. Writing 1 to status bit 1 clears it.
- R8: With `MATCH_EN` = 0, pattern and mask read as 0, `match_evt` never rises and status bit 0 stays 0. Reception and status bits 1 and 2 behave as in R1, R2, R6 and R7.
- R9: A synchronous active-high `rst` clears the received value, the status bits, the pattern and any partial word, and sets the mask to all ones. A word whose last bit arrives in a reset cycle produces no event and no stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data bit |
| ser_frame | input | 1 | High with the first bit of a word |
| host_addr | input | 2 | Register index (byte offset / 4) |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; clears word ready at index 0 |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| match_evt | output | 1 | One-cycle pattern-match event |

## Verification
The bench sends the same patterns with the mask full and partly masked. A design that ignored the mask, or compared against the old received value, would fire on the wrong words. It sends stray bits with no frame and a frame that cuts a partial word short. A design that kept a bit count across frames would store a shifted word. It overruns by sending two words without a read, writes zero to the sticky flag, and checks that the event is low in the cycle after it fires. It also places the last bit of a matching word in a reset cycle, where a design that let completion win over reset would store the word or fire the event. A second instance built without the compare path must receive the same words and never raise the event.

// File: rtl/serin_match.sv
module serin_match #(
  parameter int WIDTH    = 16,
  parameter bit MATCH_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ser_data,
  input  logic        ser_frame,
  input  logic [1:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        match_evt
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;

  logic [WIDTH-2:0] sh;
  logic [CW-1:0]    cnt;
  logic             busy;
  logic [WIDTH-1:0] rx_q;
  logic             rdy, ovr, flag;
  logic [31:0]      pat_q, msk_q;
  logic             hit;

  wire             take = ser_frame | busy;
  wire [CW-1:0]    pos  = ser_frame ? '0 : cnt;
  wire             last = take && (pos == CW'(WIDTH-1));
  wire [WIDTH-1:0] word = {sh, ser_data};
  wire             rd0  = host_rd && host_addr == 2'd0;
  wire             wst  = host_wr && host_addr == 2'd3;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      rx_q <= '0;
      rdy  <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (take) begin
        sh   <= word[WIDTH-2:0];
        busy <= !last;
        cnt  <= last ? '0 : pos + 1'b1;
      end
      if (last) rx_q <= word;
      if (last) rdy <= 1'b1;
      else if (rd0) rdy <= 1'b0;
      if (last && rdy && !rd0) ovr <= 1'b1;
      else if (wst && host_wdata[1]) ovr <= 1'b0;
    end
  end

  generate
    if (MATCH_EN) begin : g_match
      assign hit = last && (((word ^ pat_q[WIDTH-1:0]) & msk_q[WIDTH-1:0]) == '0);
      always_ff @(posedge clk) begin
        if (rst) begin
          pat_q     <= '0;
          msk_q     <= '1;
          flag      <= 1'b0;
          match_evt <= 1'b0;
        end else begin
          if (host_wr && host_addr == 2'd1) pat_q <= host_wdata;
          if (host_wr && host_addr == 2'd2) msk_q <= host_wdata;
          match_evt <= hit;
          if (hit) flag <= 1'b1;
          else if (wst && host_wdata[0]) flag <= 1'b0;
        end
      end
    end else begin : g_nomatch
      assign hit       = 1'b0;
      assign pat_q     = '0;
      assign msk_q     = '0;
      assign flag      = 1'b0;
      assign match_evt = 1'b0;
    end
  endgenerate

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = 32'(rx_q);
      2'd1:    host_rdata = pat_q;
      2'd2:    host_rdata = msk_q;
      default: host_rdata = {29'd0, rdy, ovr, flag};
    endcase
  end
endmodule

module serin_match_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             match_evt,
  input logic             rdy,
  input logic             ovr,
  input logic             flag,
  input logic             last,
  input logic [WIDTH-1:0] rx_q,
  input logic             host_wr,
  input logic [1:0]       host_addr,
  input logic [31:0]      host_wdata
);
  logic prst = 1'b0;
  always_ff @(posedge clk) prst <= rst;

  // R9
  always @(negedge clk)
    if (prst) reset_clear_chk: assert (!match_evt && rx_q == '0 && !rdy && !ovr && !flag);

  // R4
  evt_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    match_evt |-> rdy);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !(host_wr && host_addr == 2'd3 && host_wdata[0])) |=> flag);

  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr && !(host_wr && host_addr == 2'd3 && host_wdata[1])) |=> ovr);

  // R1
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(rx_q));
endmodule

bind serin_match serin_match_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .match_evt(match_evt), .rdy(rdy), .ovr(ovr),
  .flag(flag), .last(last), .rx_q(rx_q), .host_wr(host_wr),
  .host_addr(host_addr), .host_wdata(host_wdata)
);

// File: tb/serin_match_bench.sv
module serin_match_bench;
  localparam int W = 16;
  logic clk = 1'b0, rst = 1'b1, ser_data = 1'b0, ser_frame = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0, rdata, rdata_nm;
  logic evt, evt_nm;
  int checks = 0, fails = 0;
  bit nm_evt_seen = 1'b0;

  always #4 clk = ~clk;

  serin_match #(.WIDTH(W), .MATCH_EN(1'b1)) u_serin_match (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_frame(ser_frame),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(rdata), .match_evt(evt));

  serin_match #(.WIDTH(W), .MATCH_EN(1'b0)) u_serin_match_nm (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_frame(ser_frame),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(rdata_nm), .match_evt(evt_nm));

  always @(negedge clk) if (evt_nm) nm_evt_seen = 1'b1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] d);
    host_addr = a; #1 d = rdata;
  endtask

  task automatic read_rx(output logic [31:0] d);
    @(negedge clk); host_addr = 2'd0; host_rd = 1'b1; #1 d = rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  // sends a word; returns match_evt in the cycle after the last bit
  task automatic send(logic [W-1:0] v, output logic e);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk); ser_frame = (i == W - 1); ser_data = v[i];
    end
    @(negedge clk); ser_frame = 1'b0; ser_data = 1'b0; #1 e = evt;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    peek(2'd0, d); chk("R9 rx after reset", d, 0);
    peek(2'd1, d); chk("R9 pattern after reset", d, 0);
    peek(2'd2, d); chk("R9 mask after reset", d, 32'hFFFF_FFFF);
    peek(2'd3, d); chk("R9 status after reset", d, 0);
    chk("R9 evt after reset", evt, 0);
  endtask

  task automatic t_basic;
    logic [31:0] d; logic e;
    send(16'hA5C3, e);
    peek(2'd3, d); chk("R6 ready set", d & 4, 4);
    read_rx(d); chk("R1 MSB first word", d, 32'h0000_A5C3);
    peek(2'd0, d); chk("R1 nm instance word", rdata_nm, 32'h0000_A5C3);
    peek(2'd3, d); chk("R6 ready cleared by read", d & 4, 0);
  endtask

  task automatic t_exact;
    logic [31:0] d; logic e;
    wr(2'd1, 32'h0000_1234);
    send(16'h1234, e); chk("R4 exact match event", e, 1);
    @(negedge clk); chk("R4 event one cycle", evt, 0);
    peek(2'd3, d); chk("R5 flag set", d & 1, 1);
    read_rx(d);
    send(16'h1235, e); chk("R4 no event on mismatch", e, 0);
    read_rx(d);
  endtask

  task automatic t_mask;
    logic [31:0] d; logic e;
    wr(2'd3, 32'h3);
    wr(2'd1, 32'h0000_12AA); wr(2'd2, 32'h0000_FF00);
    peek(2'd2, d); chk("R3 mask readback", d, 32'h0000_FF00);
    send(16'h1299, e); chk("R4 masked bits ignored", e, 1);
    read_rx(d);
    send(16'h1399, e); chk("R4 unmasked bit differs", e, 0);
    read_rx(d);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    wr(2'd3, 32'h0);
    peek(2'd3, d); chk("R5 write 0 keeps flag", d & 1, 1);
    wr(2'd3, 32'h1);
    peek(2'd3, d); chk("R5 write 1 clears flag", d & 1, 0);
  endtask

  task automatic t_overrun;
    logic [31:0] d; logic e;
    send(16'h0F0F, e); send(16'hBEEF, e);
    peek(2'd3, d); chk("R7 overrun set", d & 2, 2);
    peek(2'd0, d); chk("R7 newest word kept", d, 32'h0000_BEEF);
    read_rx(d);
    peek(2'd3, d); chk("R7 overrun survives read", d & 2, 2);
    wr(2'd3, 32'h2);
    peek(2'd3, d); chk("R7 overrun cleared", d & 2, 0);
  endtask

  task automatic t_framing;
    logic [31:0] d; logic e;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); ser_frame = 1'b0; ser_data = i[0];
    end
    @(negedge clk); ser_data = 1'b0;
    peek(2'd3, d); chk("R2 stray bits ignored", d & 4, 0);
    peek(2'd0, d); chk("R2 rx unchanged", d, 32'h0000_BEEF);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ser_frame = (i == 0); ser_data = 1'b1;
    end
    send(16'h00C6, e);
    read_rx(d); chk("R2 frame restarts word", d, 32'h0000_00C6);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd0, 32'hDEAD_0000);
    peek(2'd0, d); chk("R3 rx read-only", d, 32'h0000_00C6);
    peek(2'd1, d); chk("R8 pattern reads 0", rdata_nm, 0);
    peek(2'd3, d); chk("R3 write to rx no status", d, 0);
  endtask

  task automatic t_rst_word;
    logic [31:0] d;
    logic [W-1:0] v = 16'h7E81;
    wr(2'd1, 32'h0000_7E81); wr(2'd2, 32'h0000_FFFF);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk); ser_frame = (i == W - 1); ser_data = v[i];
      if (i == 0) rst = 1'b1;
    end
    @(negedge clk); rst = 1'b0; ser_data = 1'b0; #1;
    chk("R9 no event in reset cycle", evt, 0);
    peek(2'd0, d); chk("R9 word dropped", d, 0);
    peek(2'd2, d); chk("R9 mask back to ones", d, 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset; t_basic; t_exact; t_mask; t_sticky;
    t_overrun; t_framing; t_regs; t_rst_word;
    chk("R8 no event without match", nm_evt_seen, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule